// File: doc/BRIEF.md
# Local Bus Hold Arbiter

This block decides who owns a processor's local bus: the processor's own bus sequencer, or an outside master that asks for the bus on an asynchronous request line. The request passes through a flop synchronizer. The bus is granted only at a bus cycle boundary, and only when no locked sequence is in progress. On a grant the block first turns off the address, data and control drivers. After a programmable number of idle clocks it raises the acknowledge. When the request drops, the acknowledge falls first, and the drivers come back on after the same gap.

Beside the ownership handshake, the block follows each processor bus cycle. A cycle opens on a start pulse from the sequencer and ends at the first clock edge that samples the active-low ready input low. A saturating counter records how many wait clocks the cycle took. The block also drives the status pins while the bus is granted away. One group of status lines is held at its last driven level by a keeper. A second group is pulled to logic one.

Top module: `bus_hold_arbiter`

## Requirements
- R1: After reset the processor owns the bus: `hlda`=0, `drv_oe`=1, `keep_en`=0, `pull_en`=0, `cyc_busy`=0.
- R2: The request `hold_req` passes through SYNC_STAGES flops. With no cycle open and no lock, `drv_oe` falls at the (SYNC_STAGES+1)-th rising edge after `hold_req` rises.
- R3: `hlda` rises exactly GAP_CYCLES edges after `drv_oe` falls. `hlda` is never 1 while `drv_oe` is 1. `hlda` is always driven to 0 or 1.
- R4: While a bus cycle is open, the bus is not released. If the synchronized request is already high, `drv_oe` falls at the edge after the edge that samples `ready_n` low.
- R5: While `lock_req` is high, the bus is not released. After the last edge that samples `lock_req` high, release waits one further edge that samples it low, so `drv_oe` falls at the second such edge.
- R6: `hlda` stays 1 for as long as `hold_req` stays 1. It falls at the (SYNC_STAGES+1)-th edge after `hold_req` drops.
- R7: `drv_oe` rises GAP_CYCLES edges after `hlda` falls.
- R8: `cyc_start` and `ready_n` have no effect on `cyc_busy` or `cyc_wait` while the bus is not owned. `ready_n` also has no effect while no cycle is open.
- R9: A `cyc_start` pulse while owned and idle sets `cyc_busy` and clears `cyc_wait`. Each following edge that samples `ready_n` high adds one to `cyc_wait`, saturating at 2^TMR_W-1. The edge that samples `ready_n` low clears `cyc_busy` and leaves `cyc_wait` holding the count.
- R10: When the bus is owned, `keep_pin` follows `keep_in`. When it is not owned, `keep_pin` holds the value `keep_in` had at the last owned edge, and `keep_en`=1.
- R11: When the bus is owned, `pull_pin` follows `pull_in`. When it is not owned, every bit of `pull_pin` is 1 and `pull_en`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hold_req | input | 1 | Asynchronous bus request from the outside master |
| lock_req | input | 1 | Locked sequence in progress (from sequencer) |
| cyc_start | input | 1 | Sequencer starts a bus cycle |
| ready_n | input | 1 | Active-low cycle terminate |
| keep_in | input | KEEP_W | Status levels to be kept during a grant |
| pull_in | input | PULL_W | Status levels to be pulled high during a grant |
| hlda | output | 1 | Hold acknowledge, always driven |
| drv_oe | output | 1 | Address/data/control driver enable; 1 = processor owns the bus |
| cyc_busy | output | 1 | Bus cycle open |
| cyc_wait | output | TMR_W | Wait clocks counted in the current or last cycle |
| keep_pin | output | KEEP_W | Kept status lines |
| keep_en | output | 1 | Keeper active on kept lines |
| pull_pin | output | PULL_W | Pulled-high status lines |
| pull_en | output | 1 | Pull-high active on pulled lines |

## Verification
Every result is due a fixed number of edges after its stimulus. Driver release comes SYNC_STAGES+1 edges after a request, or one edge after a cycle end. Under a lock it comes at the second edge that samples the lock low. The acknowledge follows release by GAP_CYCLES edges, and the return path uses the same counts in reverse. The bench drives inputs on the falling edge and samples outputs on the next falling edge. It counts the edges until each output changes and compares that count with the expected figure. Timer values are compared after exactly N edges with ready high, over a sweep that passes the saturation point.

// File: rtl/bha_pkg.sv
package bha_pkg;
   typedef enum logic [1:0] {
      ST_OWN      = 2'd0,
      ST_RELEASE  = 2'd1,
      ST_GRANTED  = 2'd2,
      ST_RETURN   = 2'd3
   } bha_state_e;
endpackage

// File: rtl/bha_sync.sv
module bha_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic q_sync
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("bha_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d_async};
   end

   assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/bha_cycle_timer.sv
module bha_cycle_timer #(
   parameter int TMR_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             owned,
   input  logic             cyc_start,
   input  logic             ready_n,
   output logic             busy,
   output logic [TMR_W-1:0] wait_cnt
);
   localparam logic [TMR_W-1:0] CNT_MAX = {TMR_W{1'b1}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         wait_cnt <= '0;
      end else if (owned) begin
         if (!busy) begin
            if (cyc_start) begin
               busy     <= 1'b1;
               wait_cnt <= '0;
            end
         end else if (!ready_n) begin
            busy <= 1'b0;
         end else if (wait_cnt != CNT_MAX) begin
            wait_cnt <= wait_cnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/bha_ctrl.sv
module bha_ctrl
   import bha_pkg::*;
#(
   parameter int GAP_CYCLES = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hold_s,
   input  logic lock_req,
   input  logic cyc_open,
   input  logic cyc_start,
   output logic owned,
   output logic ack
);
   localparam int GW = (GAP_CYCLES < 2) ? 1 : $clog2(GAP_CYCLES + 1);
   localparam logic [GW-1:0] GAP_LAST = GW'(GAP_CYCLES - 1);

   bha_state_e st_q;
   logic [GW-1:0] gap_q;
   logic          lock_q;
   logic          grant_ok;

   assign grant_ok = hold_s & ~cyc_open & ~cyc_start & ~lock_req & ~lock_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_OWN;
         gap_q  <= '0;
         lock_q <= 1'b0;
      end else begin
         lock_q <= lock_req;
         unique case (st_q)
            ST_OWN: begin
               gap_q <= '0;
               if (grant_ok) st_q <= ST_RELEASE;
            end
            ST_RELEASE: begin
               if (gap_q == GAP_LAST) begin
                  st_q  <= ST_GRANTED;
                  gap_q <= '0;
               end else begin
                  gap_q <= gap_q + 1'b1;
               end
            end
            ST_GRANTED: begin
               gap_q <= '0;
               if (!hold_s) st_q <= ST_RETURN;
            end
            ST_RETURN: begin
               if (gap_q == GAP_LAST) begin
                  st_q  <= ST_OWN;
                  gap_q <= '0;
               end else begin
                  gap_q <= gap_q + 1'b1;
               end
            end
            default: st_q <= ST_OWN;
         endcase
      end
   end

   assign owned = (st_q == ST_OWN);
   assign ack   = (st_q == ST_GRANTED);
endmodule

// File: rtl/bha_status.sv
module bha_status #(
   parameter int KEEP_W = 2,
   parameter int PULL_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              owned,
   input  logic [KEEP_W-1:0] keep_in,
   input  logic [PULL_W-1:0] pull_in,
   output logic [KEEP_W-1:0] keep_pin,
   output logic [PULL_W-1:0] pull_pin
);
   logic [KEEP_W-1:0] held_q;

   genvar i;
   generate
      for (i = 0; i < KEEP_W; i++) begin : g_keep
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     held_q[i] <= 1'b0;
            else if (owned) held_q[i] <= keep_in[i];
         end
         assign keep_pin[i] = owned ? keep_in[i] : held_q[i];
      end
      for (i = 0; i < PULL_W; i++) begin : g_pull
         assign pull_pin[i] = owned ? pull_in[i] : 1'b1;
      end
   endgenerate
endmodule

// File: rtl/bus_hold_arbiter.sv
module bus_hold_arbiter #(
   parameter int SYNC_STAGES = 2,
   parameter int GAP_CYCLES  = 1,
   parameter int TMR_W       = 8,
   parameter int KEEP_W      = 2,
   parameter int PULL_W      = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hold_req,
   input  logic              lock_req,
   input  logic              cyc_start,
   input  logic              ready_n,
   input  logic [KEEP_W-1:0] keep_in,
   input  logic [PULL_W-1:0] pull_in,
   output logic              hlda,
   output logic              drv_oe,
   output logic              cyc_busy,
   output logic [TMR_W-1:0]  cyc_wait,
   output logic [KEEP_W-1:0] keep_pin,
   output logic              keep_en,
   output logic [PULL_W-1:0] pull_pin,
   output logic              pull_en
);
   generate
      if (GAP_CYCLES < 1) begin : g_bad_gap
         $error("bus_hold_arbiter: GAP_CYCLES must be at least 1");
      end
      if (TMR_W < 2) begin : g_bad_tmr
         $error("bus_hold_arbiter: TMR_W must be at least 2");
      end
      if (KEEP_W < 1 || PULL_W < 1) begin : g_bad_w
         $error("bus_hold_arbiter: status widths must be at least 1");
      end
   endgenerate

   logic hold_s;
   logic owned;
   logic ack;

   bha_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (hold_req),
      .q_sync  (hold_s)
   );

   bha_cycle_timer #(.TMR_W(TMR_W)) u_tmr (
      .clk       (clk),
      .rst_n     (rst_n),
      .owned     (owned),
      .cyc_start (cyc_start),
      .ready_n   (ready_n),
      .busy      (cyc_busy),
      .wait_cnt  (cyc_wait)
   );

   bha_ctrl #(.GAP_CYCLES(GAP_CYCLES)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .hold_s    (hold_s),
      .lock_req  (lock_req),
      .cyc_open  (cyc_busy),
      .cyc_start (cyc_start),
      .owned     (owned),
      .ack       (ack)
   );

   bha_status #(.KEEP_W(KEEP_W), .PULL_W(PULL_W)) u_stat (
      .clk      (clk),
      .rst_n    (rst_n),
      .owned    (owned),
      .keep_in  (keep_in),
      .pull_in  (pull_in),
      .keep_pin (keep_pin),
      .pull_pin (pull_pin)
   );

   assign hlda    = ack;
   assign drv_oe  = owned;
   assign keep_en = ~owned;
   assign pull_en = ~owned;
endmodule

// File: rtl/bus_hold_arbiter_chk.sv
module bus_hold_arbiter_chk #(
   parameter int KEEP_W = 2,
   parameter int PULL_W = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              lock_req,
   input logic              ready_n,
   input logic              hlda,
   input logic              drv_oe,
   input logic              cyc_busy,
   input logic [KEEP_W-1:0] keep_pin,
   input logic              keep_en,
   input logic [PULL_W-1:0] pull_pin,
   input logic              pull_en
);
   assert_ack_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
      hlda |-> !drv_oe);

   assert_ack_after_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hlda) |-> $past(!drv_oe));

   assert_ack_known_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !$isunknown(hlda));

   assert_no_grant_mid_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_busy |-> drv_oe);

   assert_lock_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(drv_oe) && ($past(lock_req) || $past(lock_req, 2))) |-> drv_oe);

   assert_return_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(drv_oe) |-> $past(!hlda));

   assert_cycle_ends_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_busy && !ready_n) |=> !cyc_busy);

   assert_keep_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!drv_oe && $past(!drv_oe)) |-> ($stable(keep_pin) && keep_en));

   assert_pull_high_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !drv_oe |-> ((&pull_pin) && pull_en));
endmodule

bind bus_hold_arbiter bus_hold_arbiter_chk #(.KEEP_W(KEEP_W), .PULL_W(PULL_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .lock_req (lock_req),
   .ready_n  (ready_n),
   .hlda     (hlda),
   .drv_oe   (drv_oe),
   .cyc_busy (cyc_busy),
   .keep_pin (keep_pin),
   .keep_en  (keep_en),
   .pull_pin (pull_pin),
   .pull_en  (pull_en)
);

// File: tb/bus_hold_arbiter_tb.sv
module bus_hold_arbiter_tb;
   localparam int SYNC  = 2;
   localparam int GAP   = 2;
   localparam int TW    = 3;
   localparam int KW    = 2;
   localparam int PW    = 2;
   localparam int TMAX  = (1 << TW) - 1;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          hold_req, lock_req, cyc_start, ready_n;
   logic [KW-1:0] keep_in;
   logic [PW-1:0] pull_in;
   logic          hlda, drv_oe, cyc_busy, keep_en, pull_en;
   logic [TW-1:0] cyc_wait;
   logic [KW-1:0] keep_pin;
   logic [PW-1:0] pull_pin;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   bus_hold_arbiter #(.SYNC_STAGES(SYNC), .GAP_CYCLES(GAP), .TMR_W(TW),
                      .KEEP_W(KW), .PULL_W(PW)) u_dut (
      .clk(clk), .rst_n(rst_n), .hold_req(hold_req), .lock_req(lock_req),
      .cyc_start(cyc_start), .ready_n(ready_n), .keep_in(keep_in), .pull_in(pull_in),
      .hlda(hlda), .drv_oe(drv_oe), .cyc_busy(cyc_busy), .cyc_wait(cyc_wait),
      .keep_pin(keep_pin), .keep_en(keep_en), .pull_pin(pull_pin), .pull_en(pull_en)
   );

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic check(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic count_until_drv(logic lvl, output int n);
      n = 0;
      while (drv_oe != lvl && n < 40) begin tick(); n++; end
   endtask

   task automatic count_until_ack(logic lvl, output int n);
      n = 0;
      while (hlda != lvl && n < 40) begin tick(); n++; end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   // give the bus back and check R6 / R7 timing
   task automatic give_back();
      int n;
      hold_req = 1'b0;
      count_until_ack(1'b0, n);
      check("R6 ack drop delay", n, SYNC + 1);
      count_until_drv(1'b1, n);
      check("R7 driver return gap", n, GAP);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      finish_run();
   end

   initial begin
      int n;
      int w;
      rst_n = 1'b0; hold_req = 1'b0; lock_req = 1'b0; cyc_start = 1'b0;
      ready_n = 1'b1; keep_in = '0; pull_in = '0;
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      // R1 reset state
      check("R1 hlda", int'(hlda), 0);
      check("R1 drv_oe", int'(drv_oe), 1);
      check("R1 keep_en", int'(keep_en), 0);
      check("R1 pull_en", int'(pull_en), 0);
      check("R1 cyc_busy", int'(cyc_busy), 0);

      // R9 timer sweep across saturation
      for (int nw = 0; nw < 10; nw++) begin
         cyc_start = 1'b1; tick(); cyc_start = 1'b0;
         check("R9 busy at start", int'(cyc_busy), 1);
         check("R9 wait cleared", int'(cyc_wait), 0);
         repeat (nw) tick();
         w = (nw > TMAX) ? TMAX : nw;
         check("R9 wait count", int'(cyc_wait), w);
         ready_n = 1'b0; tick(); ready_n = 1'b1;
         check("R9 busy cleared", int'(cyc_busy), 0);
         check("R9 wait held", int'(cyc_wait), w);
      end

      // R8 ready with no open cycle
      w = int'(cyc_wait);
      ready_n = 1'b0; repeat (2) tick(); ready_n = 1'b1;
      check("R8 idle ready busy", int'(cyc_busy), 0);
      check("R8 idle ready wait", int'(cyc_wait), w);

      // grant sweep over patterns and hold lengths
      for (int d = 1; d <= 4; d++) begin
         keep_in = KW'(d);
         pull_in = '0;
         tick();
         check("R10 follow when owned", int'(keep_pin), d % (1 << KW));
         check("R11 follow when owned", int'(pull_pin), 0);
         hold_req = 1'b1;
         count_until_drv(1'b0, n);
         check("R2 release delay", n, SYNC + 1);
         check("R3 ack low at release", int'(hlda), 0);
         count_until_ack(1'b1, n);
         check("R3 ack gap", n, GAP);
         keep_in = ~KW'(d);
         tick();
         check("R10 keep held", int'(keep_pin), d % (1 << KW));
         check("R10 keep_en", int'(keep_en), 1);
         check("R11 pulled high", int'(pull_pin), (1 << PW) - 1);
         check("R11 pull_en", int'(pull_en), 1);
         // R8 cycle inputs ignored while granted
         w = int'(cyc_wait);
         cyc_start = 1'b1; ready_n = 1'b0; tick(); cyc_start = 1'b0; tick(); ready_n = 1'b1;
         check("R8 granted busy", int'(cyc_busy), 0);
         check("R8 granted wait", int'(cyc_wait), w);
         repeat (3 * d) tick();
         check("R6 ack held", int'(hlda), 1);
         give_back();
      end

      // R4 request during an open cycle
      cyc_start = 1'b1; tick(); cyc_start = 1'b0;
      hold_req = 1'b1;
      repeat (6) tick();
      check("R4 no release mid cycle", int'(drv_oe), 1);
      ready_n = 1'b0; tick(); ready_n = 1'b1;
      check("R4 drivers on at cycle end", int'(drv_oe), 1);
      tick();
      check("R4 release after cycle end", int'(drv_oe), 0);
      count_until_ack(1'b1, n);
      check("R3 ack gap after cycle", n, GAP);
      give_back();

      // R5 locked sequence
      lock_req = 1'b1;
      hold_req = 1'b1;
      repeat (6) tick();
      check("R5 no release under lock", int'(drv_oe), 1);
      lock_req = 1'b0; tick();
      check("R5 held one more edge", int'(drv_oe), 1);
      tick();
      check("R5 release after lock", int'(drv_oe), 0);
      count_until_ack(1'b1, n);
      check("R3 ack gap after lock", n, GAP);
      give_back();

      tick();
      finish_run();
   end
endmodule